// File: doc/BRIEF.md
# Pin Change Interrupt Detector

This block watches a group of general-purpose input pins and raises one shared interrupt flag whenever any pin that software has enabled changes logic level, in either direction. Each pin passes through two registers: a capture stage and then a synchroniser stage. A pin has changed when the two stages hold different values. That per-pin change is gated by a mask bit, and the gated changes are ORed into a single set event for the group flag.

The group flag is sticky. It holds until software pulses the clear input. The interrupt request output is the flag qualified by a group enable input. Software loads the mask through a simple write strobe with data. All pins here are plain control and status signals: there is no streaming interface and therefore no valid/ready handshake or back-pressure. Vectoring and priority between interrupt sources belong to the interrupt controller outside this block.

Top module: `pcd_top`

## Requirements
- R1: After reset, flag_o and irq_o are 0 and every mask bit is 0, so pin toggles made before any mask write leave flag_o at 0.
- R2: A level change on a pin whose mask bit is 1 sets flag_o. If the new level is present before clock edge k, flag_o is still 0 after edge k and reads 1 after edge k+1. Rising and falling changes behave alike.
- R3: A level change on a pin whose mask bit is 0 never sets flag_o.
- R4: Once set, flag_o stays 1 for as long as flag_clr_i is low, whatever the pins do.
- R5: When flag_clr_i is 1 at a clock edge and no set event happens at that edge, flag_o reads 0 after that edge.
- R6: When a set event and flag_clr_i fall on the same edge, the set wins and flag_o reads 1 after that edge.
- R7: irq_o is 1 exactly when flag_o is 1 and grp_en_i is 1. A change of grp_en_i alters irq_o without altering flag_o.
- R8: When mask_we_i is 1 at a clock edge, mask_wdata_i becomes the mask at that edge. Bit i of the mask gates pins_i[i].
- R9: A single pin change produces exactly one set event. After that event has been cleared, flag_o stays 0 while the pins are held steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pins_i | input | 8 | Monitored pins |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data, one bit per pin |
| flag_clr_i | input | 1 | Clears the group flag when 1 |
| grp_en_i | input | 1 | Group interrupt enable |
| flag_o | output | 1 | Sticky group change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A set event and a software clear can land on the same edge. The bench provokes this by raising an enabled pin and then asserting the clear on the very next edge, which is the edge where the change reaches the comparison. The flag must then read 1 afterwards. A mask write is also issued on the same edge as a pending change, and the bench judges whether that change is gated by the new mask value.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned PCD_PINS = 8;

  // control inputs of the sticky flag
  typedef struct packed {
    logic set;
    logic clr;
  } pcd_flag_ctl_t;
endpackage

// File: rtl/pcd_sample.sv
module pcd_sample #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] cap_q,
  output logic [W-1:0] syn_q
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q[g] <= 1'b0;
        syn_q[g] <= 1'b0;
      end else begin
        cap_q[g] <= pins_i[g];
        syn_q[g] <= cap_q[g];
      end
    end
  end
endmodule

// File: rtl/pcd_mask.sv
module pcd_mask #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end
endmodule

// File: rtl/pcd_flag.sv
module pcd_flag
  import pcd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  pcd_flag_ctl_t ctl_i,
  output logic          flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (ctl_i.set) flag_q <= 1'b1;   // set has priority
    else if (ctl_i.clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/pcd_top.sv
module pcd_top
  import pcd_pkg::*;
#(
  parameter int unsigned W = PCD_PINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic         flag_clr_i,
  input  logic         grp_en_i,
  output logic         flag_o,
  output logic         irq_o
);
  logic [W-1:0]  cap_q, syn_q, mask_q, chg;
  logic          set_evt;
  pcd_flag_ctl_t ctl;

  pcd_sample #(.W(W)) u_sample (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .cap_q(cap_q), .syn_q(syn_q)
  );

  pcd_mask #(.W(W)) u_mask (
    .clk(clk), .rst_n(rst_n), .we_i(mask_we_i), .wdata_i(mask_wdata_i), .mask_q(mask_q)
  );

  // per-pin change, gated by mask, then collapsed to one set line
  assign chg     = (cap_q ^ syn_q) & mask_q;
  assign set_evt = |chg;
  assign ctl.set = set_evt;
  assign ctl.clr = flag_clr_i;

  pcd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .flag_q(flag_o)
  );

  assign irq_o = flag_o & grp_en_i;
endmodule

// File: rtl/pcd_chk.sv
module pcd_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mask_we_i,
  input logic [W-1:0] mask_wdata_i,
  input logic [W-1:0] mask_q,
  input logic         set_evt,
  input logic         flag_clr_i,
  input logic         grp_en_i,
  input logic         flag_o,
  input logic         irq_o
);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !set_evt) |=> !flag_o);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_o);
  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_evt));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_en_i |-> !irq_o);
  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_q == $past(mask_wdata_i)));
endmodule

bind pcd_top pcd_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
  .mask_q(mask_q), .set_evt(set_evt), .flag_clr_i(flag_clr_i),
  .grp_en_i(grp_en_i), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/pcd_top_tb.sv
`timescale 1ns/1ps
module pcd_top_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pins = '0;
  logic         mwe = 1'b0;
  logic [W-1:0] mdata = '0;
  logic         clr = 1'b0;
  logic         en = 1'b1;
  logic         flag, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic  flag;
    logic  irq;
    string tag;
  } exp_t;
  exp_t sbq[$];

  // requirement-level model state
  logic [W-1:0] m_a = '0, m_b = '0, m_mask = '0;
  logic         m_flag = 1'b0;

  always #2.5 clk = ~clk;

  pcd_top #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .mask_we_i(mwe),
    .mask_wdata_i(mdata), .flag_clr_i(clr), .grp_en_i(en),
    .flag_o(flag), .irq_o(irq)
  );

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic [W-1:0] p, input logic we, input logic [W-1:0] wd,
                      input logic c, input logic e, input string tag);
    exp_t x;
    logic evt;
    pins = p; mwe = we; mdata = wd; clr = c; en = e;
    evt = |((m_a ^ m_b) & m_mask);
    if (evt)    m_flag = 1'b1;
    else if (c) m_flag = 1'b0;
    m_b = m_a; m_a = p;
    if (we) m_mask = wd;
    x.flag = m_flag; x.irq = m_flag & e; x.tag = tag;
    sbq.push_back(x);
    @(negedge clk);
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      exp_t x;
      x = sbq.pop_front();
      n_chk++;
      if (flag !== x.flag || irq !== x.irq) begin
        n_fail++;
        $display("FAIL %s flag=%0b irq=%0b expected flag=%0b irq=%0b", x.tag, flag, irq, x.flag, x.irq);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (flag !== 1'b0 || irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset flag=%0b irq=%0b expected 0 0", flag, irq);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1: mask is zero after reset
    step(8'hFF, 0, 8'h00, 0, 1, "R1 toggle all unmasked");
    step(8'h00, 0, 8'h00, 0, 1, "R1 toggle back");
    step(8'h00, 0, 8'h00, 0, 1, "R1 quiet");
    step(8'h00, 0, 8'h00, 0, 1, "R1 quiet");
    // R8: enable pin 2 only
    step(8'h00, 1, 8'h04, 0, 1, "R8 mask write");
    // R3: pin 0 masked off
    step(8'h01, 0, 8'h00, 0, 1, "R3 masked pin");
    step(8'h00, 0, 8'h00, 0, 1, "R3 masked pin back");
    step(8'h00, 0, 8'h00, 0, 1, "R3 settle");
    step(8'h00, 0, 8'h00, 0, 1, "R3 settle");
    // R2: rising edge on pin 2
    step(8'h04, 0, 8'h00, 0, 1, "R2 rise first edge");
    step(8'h04, 0, 8'h00, 0, 1, "R2 rise second edge");
    // R4: sticky
    for (int i = 0; i < 3; i++) step(8'h04, 0, 8'h00, 0, 1, "R4 hold");
    step(8'h05, 0, 8'h00, 0, 1, "R4 other pin moves");
    // R7: enable gating
    step(8'h05, 0, 8'h00, 0, 0, "R7 enable off");
    step(8'h05, 0, 8'h00, 0, 1, "R7 enable on");
    // R5 and R9
    step(8'h05, 0, 8'h00, 1, 1, "R5 clear");
    for (int i = 0; i < 3; i++) step(8'h05, 0, 8'h00, 0, 1, "R9 steady");
    // R2: falling edge on pin 2
    step(8'h01, 0, 8'h00, 0, 1, "R2 fall first edge");
    step(8'h01, 0, 8'h00, 0, 1, "R2 fall second edge");
    step(8'h01, 0, 8'h00, 1, 1, "R5 clear again");
    step(8'h01, 0, 8'h00, 0, 1, "R9 steady");
    // R6: clear on the edge where the set event arrives
    step(8'h05, 0, 8'h00, 0, 1, "R6 change captured");
    step(8'h05, 1, 8'hFF, 1, 1, "R6 set beats clear");
    step(8'h05, 0, 8'h00, 1, 1, "R6 clear after");
    // R8: new mask covers all pins, multi-pin pattern
    step(8'hA5, 0, 8'h00, 0, 1, "R8 pattern captured");
    step(8'hA5, 0, 8'h00, 0, 1, "R8 wide mask sets");
    step(8'hA5, 0, 8'h00, 1, 1, "R5 clear wide");
    // R8: change pending while mask is narrowed to pin 7 only
    step(8'hA4, 0, 8'h00, 0, 1, "R8 pin0 change");
    step(8'hA4, 1, 8'h80, 0, 1, "R8 gated by old mask");
    step(8'hA4, 0, 8'h00, 1, 1, "R5 clear");
    step(8'hA5, 0, 8'h00, 0, 1, "R3 pin0 now masked");
    step(8'hA5, 0, 8'h00, 0, 1, "R3 no set");
    step(8'h25, 0, 8'h00, 0, 1, "R2 pin7 change");
    step(8'h25, 0, 8'h00, 0, 1, "R2 pin7 sets");
    step(8'h25, 0, 8'h00, 0, 1, "R4 hold");
    @(negedge clk);
    finish_run();
  end
endmodule